// File: doc/BRIEF.md
# Skewed Associative Lookup and Victim Selector

This block holds the valid bits and tags of a cache with one to four banks, in which each bank finds its slot with its own hash of the memory block number. Each lookup presents a block number. The block hashes it once per bank, reads the candidate entry in every bank and compares the stored tags. It then reports either a hit, with the bank and the slot, or a miss, with the bank and slot that now hold the new block. A miss installs the new block at once. An empty candidate is used before any occupied one, and the lowest bank wins among empty candidates. When every candidate is occupied, an external replacement-choice input names the bank to overwrite.

Bank k forms its index from two n-bit groups of the block number. The low group is bit-reversed and then rotated left by k. The next group is rotated left by one. The two results are XORed. Because the rotation differs per bank, two blocks that collide in one bank usually land in different slots in the others. Data storage and write policy belong to the surrounding cache. A separate port clears a single entry.

Top module: `skew_victim_sel`

## Requirements
- R1: After reset every entry is empty and rspValid and rspHit are 0; the first lookup after reset misses and installs into bank 0.
- R2: With n = IDX_W, g1 = blk[n-1:0] and g2 = blk[2n-1:n], the slot in bank k is rotl(reverse(g1), k mod n) XOR rotl(g2, 1), where rotl rotates toward the MSB. rspIdx reports the slot in the reported bank.
- R3: A lookup whose full block number is held valid in its candidate slot of some bank gives rspHit=1, with rspBank set to that bank (binary) and rspIdx set to that slot.
- R4: On a miss with at least one empty candidate, the block is installed in the lowest-numbered bank whose candidate is empty, and that bank is reported with rspHit=0.
- R5: On a miss where all candidates are valid, the block replaces the entry in bank replChoice, and that bank is reported.
- R6: The full block number is stored, so blocks that share every candidate slot but differ in bits above 2n never hit on each other.
- R7: invEn clears the entry at bank invBank and slot invIdx. A lookup presented in the same cycle is dropped, and no response follows it.
- R8: The response is registered. rspValid is 1 exactly one cycle after an accepted lookup. rspHit, rspBank and rspIdx are 0 when rspValid is 0.
- R9: At most one bank hits for any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request |
| reqBlk | input | BLK_W | Memory block number |
| replChoice | input | 2 | Bank to replace when all candidates are valid |
| invEn | input | 1 | Clear one entry |
| invBank | input | 2 | Bank of the entry to clear |
| invIdx | input | IDX_W | Slot of the entry to clear |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Lookup hit |
| rspBank | output | 2 | Hit bank or fill bank |
| rspIdx | output | IDX_W | Slot within rspBank |

## Verification
The case hardest to reach is a full candidate set, where every bank's slot for one block is occupied. This is what makes the replacement input matter. From the ports it takes a set of blocks that collide in all banks at once. The stimulus gets it by keeping both hashed groups fixed and varying only the bits above them: one fill per bank, then a fifth such block. A later lookup of the evicted block shows that the full block number was kept. Same-cycle invalidation is reached by raising invEn together with a request.

// File: rtl/skew_pkg.sv
package skew_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic       install;
    logic [1:0] instBank;
    logic       clear;
    logic [1:0] clrBank;
  } strobe_t;
endpackage

// File: rtl/skew_datapath.sv
module skew_datapath
  import skew_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 4,
  parameter int BLK_W     = 12
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [BLK_W-1:0]                reqBlk,
  input  logic [IDX_W-1:0]                clrIdx,
  input  strobe_t                         stb,
  output logic [NUM_BANKS-1:0][IDX_W-1:0] idxVec,
  output logic [NUM_BANKS-1:0]            hitVec,
  output logic [NUM_BANKS-1:0]            candValid
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] grpLo, grpHi;
  assign grpLo = reqBlk[IDX_W-1:0];
  assign grpHi = reqBlk[2*IDX_W-1:IDX_W];

  // second permutation: rotate left by one (wires only)
  logic [IDX_W-1:0] permHi;
  always_comb begin
    for (int i = 0; i < IDX_W; i++) permHi[(i + 1) % IDX_W] = grpHi[i];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [IDX_W-1:0] rotLo;
    logic [DEPTH-1:0] validMem;
    logic [BLK_W-1:0] tagMem [DEPTH];

    // first permutation (bit reverse), then rotate by bank number
    always_comb begin
      for (int i = 0; i < IDX_W; i++) rotLo[(i + b) % IDX_W] = grpLo[IDX_W-1-i];
    end

    assign idxVec[b]    = rotLo ^ permHi;
    assign candValid[b] = validMem[idxVec[b]];
    assign hitVec[b]    = candValid[b] && (tagMem[idxVec[b]] == reqBlk);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validMem <= '0;
      end else begin
        if (stb.clear && stb.clrBank == 2'(b)) validMem[clrIdx] <= 1'b0;
        if (stb.install && stb.instBank == 2'(b)) validMem[idxVec[b]] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (stb.install && stb.instBank == 2'(b)) tagMem[idxVec[b]] <= reqBlk;
    end

    // R4
    install_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.install && stb.instBank == 2'(b) |=>
        validMem[$past(idxVec[b])] && tagMem[$past(idxVec[b])] == $past(reqBlk));
    // R7
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.clear && stb.clrBank == 2'(b) |=> !validMem[$past(clrIdx)]);
  end
endmodule

// File: rtl/skew_control.sv
module skew_control
  import skew_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic                            invEn,
  input  logic [1:0]                      invBank,
  input  logic [1:0]                      replChoice,
  input  logic [NUM_BANKS-1:0][IDX_W-1:0] idxVec,
  input  logic [NUM_BANKS-1:0]            hitVec,
  input  logic [NUM_BANKS-1:0]            candValid,
  output strobe_t                         stb,
  output logic                            rspValid,
  output logic                            rspHit,
  output logic [1:0]                      rspBank,
  output logic [IDX_W-1:0]                rspIdx
);
  localparam logic [2:0] NB = 3'(NUM_BANKS);

  logic       accept, hitAny, anyEmpty;
  logic [1:0] hitBank, emptyBank, victim, selBank;
  logic [IDX_W-1:0] selIdx;

  assign accept   = reqValid && !invEn;
  assign hitAny   = |hitVec;
  assign anyEmpty = ~&candValid;

  always_comb begin
    hitBank   = '0;
    emptyBank = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (hitVec[b]) hitBank = 2'(b);
    for (int b = NUM_BANKS - 1; b >= 0; b--)
      if (!candValid[b]) emptyBank = 2'(b);
  end

  always_comb begin
    if (anyEmpty)                    victim = emptyBank;
    else if ({1'b0, replChoice} < NB) victim = replChoice;
    else                             victim = '0;
    selBank = hitAny ? hitBank : victim;
    selIdx  = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (selBank == 2'(b)) selIdx = idxVec[b];
  end

  always_comb begin
    stb.install  = accept && !hitAny;
    stb.instBank = victim;
    stb.clear    = invEn;
    stb.clrBank  = invBank;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspBank  <= '0;
      rspIdx   <= '0;
    end else begin
      rspValid <= accept;
      rspHit   <= accept && hitAny;
      rspBank  <= accept ? selBank : 2'd0;
      rspIdx   <= accept ? selIdx : '0;
    end
  end

  // R9
  single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);
  // R8
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid && !rspHit && rspBank == 2'd0);
  // R3
  bank_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> {1'b0, rspBank} < NB);
endmodule

// File: rtl/skew_victim_sel.sv
module skew_victim_sel
  import skew_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 4,
  parameter int BLK_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [BLK_W-1:0] reqBlk,
  input  logic [1:0]       replChoice,
  input  logic             invEn,
  input  logic [1:0]       invBank,
  input  logic [IDX_W-1:0] invIdx,
  output logic             rspValid,
  output logic             rspHit,
  output logic [1:0]       rspBank,
  output logic [IDX_W-1:0] rspIdx
);
  strobe_t                         stb;
  logic [NUM_BANKS-1:0][IDX_W-1:0] idxVec;
  logic [NUM_BANKS-1:0]            hitVec, candValid;

  skew_datapath #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqBlk(reqBlk), .clrIdx(invIdx), .stb(stb),
    .idxVec(idxVec), .hitVec(hitVec), .candValid(candValid)
  );

  skew_control #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .invEn(invEn),
    .invBank(invBank), .replChoice(replChoice), .idxVec(idxVec),
    .hitVec(hitVec), .candValid(candValid), .stb(stb),
    .rspValid(rspValid), .rspHit(rspHit), .rspBank(rspBank), .rspIdx(rspIdx)
  );
endmodule

// File: tb/sim_skew_victim_sel.sv
module sim_skew_victim_sel;
  localparam int NB = 4, IW = 4, BW = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, invEn = 1'b0;
  logic [BW-1:0] reqBlk = '0;
  logic [1:0] replChoice = '0, invBank = '0;
  logic [IW-1:0] invIdx = '0;
  logic rspValid, rspHit;
  logic [1:0] rspBank;
  logic [IW-1:0] rspIdx;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  skew_victim_sel #(.NUM_BANKS(NB), .IDX_W(IW), .BLK_W(BW)) u0 (.*);

  // R2 hash, computed from the stated formula
  function automatic logic [IW-1:0] slotOf(logic [BW-1:0] blk, int k);
    logic [IW-1:0] lo, hi, rev, r1, h1;
    lo = blk[IW-1:0];
    hi = blk[2*IW-1:IW];
    for (int i = 0; i < IW; i++) rev[i] = lo[IW-1-i];
    r1 = rev;
    for (int s = 0; s < k % IW; s++) r1 = {r1[IW-2:0], r1[IW-1]};
    h1 = {hi[IW-2:0], hi[IW-1]};
    return r1 ^ h1;
  endfunction

  function automatic logic [BW-1:0] blkA(int u);
    return {4'(u), 4'h5, 4'h3};
  endfunction

  task automatic chk(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lookup(string req, logic [BW-1:0] blk, logic [1:0] repl,
                        bit expHit, int expBank);
    @(negedge clk);
    reqValid = 1'b1; reqBlk = blk; replChoice = repl;
    @(negedge clk);
    chk({req, " rspValid"}, int'(rspValid), 1);
    chk({req, " rspHit"}, int'(rspHit), int'(expHit));
    chk({req, " rspBank"}, int'(rspBank), expBank);
    chk({req, " rspIdx (R2)"}, int'(rspIdx), int'(slotOf(blk, expBank)));
    reqValid = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 rspValid", int'(rspValid), 0);
    chk("R1 rspHit", int'(rspHit), 0);
    rstN = 1'b1;
  endtask

  task automatic t_fill;
    // same hashed groups, different upper bits: same slot in every bank
    lookup("R1 first", blkA(0), 2'd3, 1'b0, 0);
    for (int u = 1; u < 4; u++) lookup("R4 fill", blkA(u), 2'd3, 1'b0, u);
  endtask

  task automatic t_skew;
    lookup("R2 other slot", {4'h0, 4'h0, 4'h1}, 2'd3, 1'b0, 0);
  endtask

  task automatic t_hit;
    for (int u = 0; u < 4; u++) lookup("R3 hit", blkA(u), 2'd0, 1'b1, u);
    lookup("R3 hit other", {4'h0, 4'h0, 4'h1}, 2'd2, 1'b1, 0);
  endtask

  task automatic t_repl;
    lookup("R5 replace", blkA(4), 2'd2, 1'b0, 2);
    lookup("R3 new hit", blkA(4), 2'd0, 1'b1, 2);
    lookup("R6 evicted", blkA(2), 2'd0, 1'b0, 0);
    lookup("R5 replace3", blkA(0), 2'd3, 1'b0, 3);
    lookup("R6 no alias", blkA(9), 2'd1, 1'b0, 1);
  endtask

  task automatic t_inv;
    // now bank1 holds A9 in the shared slot
    @(negedge clk);
    invEn = 1'b1; invBank = 2'd1; invIdx = slotOf(blkA(9), 1);
    reqValid = 1'b1; reqBlk = blkA(9);
    @(negedge clk);
    chk("R7 dropped rspValid", int'(rspValid), 0);
    chk("R7 dropped rspHit", int'(rspHit), 0);
    invEn = 1'b0; reqValid = 1'b0;
    lookup("R7 cleared refill", blkA(9), 2'd3, 1'b0, 1);
    lookup("R7 refill hit", blkA(9), 2'd0, 1'b1, 1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R8 idle rspValid", int'(rspValid), 0);
    chk("R8 idle rspBank", int'(rspBank), 0);
    chk("R8 idle rspIdx", int'(rspIdx), 0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_skew();
    t_hit();
    t_repl();
    t_inv();
    t_idle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule